// File: doc/BRIEF.md
# Register Rename Map with Buffer-Ready Flag

This block is the rename table of an out-of-order core. It keeps one entry for each architectural register. Each entry holds a reorder-buffer tag and a flag that marks whether the tagged result has already been produced. At dispatch, up to `N_SRC` source registers are looked up, and the block reports where each operand must come from:

- the architectural register file;
- a completed result held in the reorder buffer;
- a tag that the operand must wait on.

In the same cycle, the destination register of the dispatching instruction is renamed to its newly allocated tag.

Completion and retirement events from the reorder buffer update the table. Each event carries a tag and a destination register. The event is applied only when the entry still holds that tag, so a younger rename of the same register is never disturbed. A flush returns every register to its architectural state.

Dispatch uses a valid/ready handshake. A dispatch is accepted in a cycle where both `disp_valid_i` and `disp_ready_o` are high. `disp_ready_o` is low only during a flush cycle, and a dispatch offered in that cycle must be held by the sender. Completion, retirement and flush are single-cycle pulses with no back-pressure. Tag value 0 is reserved and never allocated.

Top module: `rename_map_table`

## Requirements
- R1: After reset, or in the cycle after `flush_i`, every register reports as held in the register file (kind code 0, tag 0).
- R2: An accepted dispatch with a valid destination makes that register report kind 1 (wait) with the new tag from the next cycle on.
- R3: A completion whose tag and register match the register's current entry makes it report kind 2 (in buffer) with the same tag from the next cycle on.
- R4: A completion whose tag no longer matches the register's entry leaves that entry unchanged.
- R5: A retirement whose tag and register match the current entry returns the register to kind 0 with tag 0 from the next cycle on.
- R6: A retirement whose tag no longer matches the entry leaves it unchanged.
- R7: Source lookups use the table as it stood before this cycle's destination write, so a source naming the same register as the destination sees the previous mapping.
- R8: A completion in the same cycle as a lookup is bypassed: a source whose entry holds that tag reports kind 2.
- R9: A retirement in the same cycle as a lookup is bypassed: a source whose entry holds that tag reports kind 0 with tag 0.
- R10: When a dispatch renames a register in the same cycle that a completion or retirement targets it, the new rename wins.
- R11: `disp_ready_o` is low in a flush cycle, and a dispatch offered in that cycle leaves no mapping behind.
- R12: Kind codes are 0 = register file, 1 = wait on tag, 2 = in buffer. Kind 0 always carries tag 0, and a source with its valid low reports kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Return all registers to the register file |
| disp_valid_i | input | 1 | Dispatch offered |
| disp_ready_o | output | 1 | Dispatch can be accepted |
| disp_src_valid_i | input | N_SRC | Per-source lookup enable |
| disp_src_reg_i | input | N_SRC x IDX_W | Source register numbers |
| disp_dst_valid_i | input | 1 | Dispatch writes a destination |
| disp_dst_reg_i | input | IDX_W | Destination register number |
| disp_dst_tag_i | input | TAG_W | Newly allocated tag, nonzero |
| cmpl_valid_i | input | 1 | Completion event |
| cmpl_reg_i | input | IDX_W | Destination register of the completing instruction |
| cmpl_tag_i | input | TAG_W | Tag of the completing instruction |
| ret_valid_i | input | 1 | Retirement event |
| ret_reg_i | input | IDX_W | Destination register of the retiring instruction |
| ret_tag_i | input | TAG_W | Tag of the retiring instruction |
| src_kind_o | output | N_SRC x 2 | Operand source kind per lookup |
| src_tag_o | output | N_SRC x TAG_W | Operand tag per lookup |

## Verification
The bench renames one register twice and then sends a completion and a retirement for the older tag. A design without the tag-match guard would mark the newer producer ready, or drop it to the register file, so a consumer would read a value that does not exist yet. It looks up a register that is being renamed in the same cycle. Reading the table after the write would make an instruction such as `r1 = r1 + 4` wait on itself. It also drives completions and retirements in the lookup cycle, and a missing bypass would leave a consumer waiting on a tag that has already been broadcast. Finally, it collides a dispatch with a completion to the same register, and offers a dispatch during a flush, where a wrong priority would leave a stale or half-flushed mapping.

// File: rtl/rename_map_pkg.sv
package rename_map_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_WAIT    = 2'd1,
    SRC_ROB     = 2'd2
  } src_kind_e;

endpackage

// File: rtl/rename_map_entry.sv
module rename_map_entry #(
  parameter int TAG_W = 6,
  parameter int IDX_W = 5,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             disp_fire_i,
  input  logic [IDX_W-1:0] disp_reg_i,
  input  logic [TAG_W-1:0] disp_tag_i,
  input  logic             cmpl_valid_i,
  input  logic [IDX_W-1:0] cmpl_reg_i,
  input  logic [TAG_W-1:0] cmpl_tag_i,
  input  logic             ret_valid_i,
  input  logic [IDX_W-1:0] ret_reg_i,
  input  logic [TAG_W-1:0] ret_tag_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             rdy_o
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

  logic [TAG_W-1:0] tag_q, tag_d;
  logic             rdy_q, rdy_d;
  logic             live;
  logic             hit_disp, hit_cmpl, hit_ret;

  assign live     = (tag_q != '0);
  assign hit_disp = disp_fire_i && (disp_reg_i == MY_IDX);
  assign hit_cmpl = cmpl_valid_i && (cmpl_reg_i == MY_IDX) && live && (cmpl_tag_i == tag_q);
  assign hit_ret  = ret_valid_i && (ret_reg_i == MY_IDX) && live && (ret_tag_i == tag_q);

  // Priority: flush, newest rename, retirement, completion.
  always_comb begin
    tag_d = tag_q;
    rdy_d = rdy_q;
    if (flush_i) begin
      tag_d = '0;
      rdy_d = 1'b0;
    end else if (hit_disp) begin
      tag_d = disp_tag_i;
      rdy_d = 1'b0;
    end else if (hit_ret) begin
      tag_d = '0;
      rdy_d = 1'b0;
    end else if (hit_cmpl) begin
      rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      tag_q <= tag_d;
      rdy_q <= rdy_d;
    end
  end

  assign tag_o = tag_q;
  assign rdy_o = rdy_q;

endmodule

// File: rtl/rename_map_lookup.sv
module rename_map_lookup
  import rename_map_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 6,
  parameter int IDX_W    = 5
) (
  input  logic                           src_valid_i,
  input  logic [IDX_W-1:0]               src_reg_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0] map_tag_i,
  input  logic [NUM_REGS-1:0]            map_rdy_i,
  input  logic                           cmpl_valid_i,
  input  logic [IDX_W-1:0]               cmpl_reg_i,
  input  logic [TAG_W-1:0]               cmpl_tag_i,
  input  logic                           ret_valid_i,
  input  logic [IDX_W-1:0]               ret_reg_i,
  input  logic [TAG_W-1:0]               ret_tag_i,
  output logic [1:0]                     kind_o,
  output logic [TAG_W-1:0]               tag_o
);

  logic [TAG_W-1:0] ent_tag;
  logic             ent_rdy;
  logic             byp_cmpl, byp_ret;
  src_kind_e        kind;

  assign ent_tag  = map_tag_i[src_reg_i];
  assign ent_rdy  = map_rdy_i[src_reg_i];
  assign byp_cmpl = cmpl_valid_i && (cmpl_reg_i == src_reg_i) && (cmpl_tag_i == ent_tag);
  assign byp_ret  = ret_valid_i && (ret_reg_i == src_reg_i) && (ret_tag_i == ent_tag);

  always_comb begin
    kind  = SRC_REGFILE;
    tag_o = '0;
    if (src_valid_i && (ent_tag != '0) && !byp_ret) begin
      tag_o = ent_tag;
      kind  = (ent_rdy || byp_cmpl) ? SRC_ROB : SRC_WAIT;
    end
  end

  assign kind_o = kind;

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 6,
  parameter int N_SRC    = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic                        disp_valid_i,
  output logic                        disp_ready_o,
  input  logic [N_SRC-1:0]            disp_src_valid_i,
  input  logic [N_SRC-1:0][IDX_W-1:0] disp_src_reg_i,
  input  logic                        disp_dst_valid_i,
  input  logic [IDX_W-1:0]            disp_dst_reg_i,
  input  logic [TAG_W-1:0]            disp_dst_tag_i,
  input  logic                        cmpl_valid_i,
  input  logic [IDX_W-1:0]            cmpl_reg_i,
  input  logic [TAG_W-1:0]            cmpl_tag_i,
  input  logic                        ret_valid_i,
  input  logic [IDX_W-1:0]            ret_reg_i,
  input  logic [TAG_W-1:0]            ret_tag_i,
  output logic [N_SRC-1:0][1:0]       src_kind_o,
  output logic [N_SRC-1:0][TAG_W-1:0] src_tag_o
);

  logic [NUM_REGS-1:0][TAG_W-1:0] map_tag;
  logic [NUM_REGS-1:0]            map_rdy;
  logic                           disp_fire;

  assign disp_ready_o = !flush_i;
  assign disp_fire    = disp_valid_i && disp_ready_o && disp_dst_valid_i;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
    rename_map_entry #(.TAG_W(TAG_W), .IDX_W(IDX_W), .IDX(r)) i_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush_i),
      .disp_fire_i  (disp_fire),
      .disp_reg_i   (disp_dst_reg_i),
      .disp_tag_i   (disp_dst_tag_i),
      .cmpl_valid_i (cmpl_valid_i),
      .cmpl_reg_i   (cmpl_reg_i),
      .cmpl_tag_i   (cmpl_tag_i),
      .ret_valid_i  (ret_valid_i),
      .ret_reg_i    (ret_reg_i),
      .ret_tag_i    (ret_tag_i),
      .tag_o        (map_tag[r]),
      .rdy_o        (map_rdy[r])
    );
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    rename_map_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_lookup (
      .src_valid_i  (disp_src_valid_i[s]),
      .src_reg_i    (disp_src_reg_i[s]),
      .map_tag_i    (map_tag),
      .map_rdy_i    (map_rdy),
      .cmpl_valid_i (cmpl_valid_i),
      .cmpl_reg_i   (cmpl_reg_i),
      .cmpl_tag_i   (cmpl_tag_i),
      .ret_valid_i  (ret_valid_i),
      .ret_reg_i    (ret_reg_i),
      .ret_tag_i    (ret_tag_i),
      .kind_o       (src_kind_o[s]),
      .tag_o        (src_tag_o[s])
    );
  end

endmodule

// File: rtl/rename_map_table_chk.sv
module rename_map_table_chk #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 6,
  parameter int N_SRC    = 2,
  parameter int IDX_W    = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           flush_i,
  input logic                           disp_valid_i,
  input logic                           disp_ready_o,
  input logic                           disp_dst_valid_i,
  input logic [IDX_W-1:0]               disp_dst_reg_i,
  input logic [TAG_W-1:0]               disp_dst_tag_i,
  input logic                           cmpl_valid_i,
  input logic [IDX_W-1:0]               cmpl_reg_i,
  input logic [TAG_W-1:0]               cmpl_tag_i,
  input logic                           ret_valid_i,
  input logic [IDX_W-1:0]               ret_reg_i,
  input logic [TAG_W-1:0]               ret_tag_i,
  input logic [N_SRC-1:0][1:0]          src_kind_o,
  input logic [N_SRC-1:0][TAG_W-1:0]    src_tag_o,
  input logic [NUM_REGS-1:0][TAG_W-1:0] map_tag,
  input logic [NUM_REGS-1:0]            map_rdy
);

  logic fire;
  assign fire = disp_valid_i && disp_ready_o && disp_dst_valid_i;

  p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (map_tag == '0) && (map_rdy == '0));

  p_disp_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (map_tag[$past(disp_dst_reg_i)] == $past(disp_dst_tag_i))
             && !map_rdy[$past(disp_dst_reg_i)]);

  p_retire_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid_i && !flush_i && (ret_tag_i != '0) && (map_tag[ret_reg_i] == ret_tag_i)
     && !(fire && (disp_dst_reg_i == ret_reg_i)))
    |=> (map_tag[$past(ret_reg_i)] == '0));

  p_ready_low_in_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !disp_ready_o);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    p_ready_only_by_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(map_rdy[r]) |-> ($past(cmpl_valid_i) && ($past(cmpl_reg_i) == IDX_W'(r))
                             && ($past(cmpl_tag_i) == map_tag[r])));
    p_ready_has_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      map_rdy[r] |-> (map_tag[r] != '0));
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    p_kind_tag_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_kind_o[s] == 2'd0) == (src_tag_o[s] == '0)) && (src_kind_o[s] != 2'd3));
  end

endmodule

bind rename_map_table rename_map_table_chk #(
  .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .N_SRC(N_SRC), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .disp_valid_i(disp_valid_i),
  .disp_ready_o(disp_ready_o), .disp_dst_valid_i(disp_dst_valid_i),
  .disp_dst_reg_i(disp_dst_reg_i), .disp_dst_tag_i(disp_dst_tag_i),
  .cmpl_valid_i(cmpl_valid_i), .cmpl_reg_i(cmpl_reg_i), .cmpl_tag_i(cmpl_tag_i),
  .ret_valid_i(ret_valid_i), .ret_reg_i(ret_reg_i), .ret_tag_i(ret_tag_i),
  .src_kind_o(src_kind_o), .src_tag_o(src_tag_o),
  .map_tag(map_tag), .map_rdy(map_rdy)
);

// File: tb/test_rename_map_table.sv
module test_rename_map_table;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 32;
  localparam int TAG_W      = 6;
  localparam int N_SRC      = 2;
  localparam int IDX_W      = $clog2(NUM_REGS);

  localparam logic [1:0] K_RF   = 2'd0;
  localparam logic [1:0] K_WAIT = 2'd1;
  localparam logic [1:0] K_ROB  = 2'd2;

  logic                        clk = 1'b0;
  logic                        rst_n;
  logic                        flush_i;
  logic                        disp_valid_i;
  logic                        disp_ready_o;
  logic [N_SRC-1:0]            disp_src_valid_i;
  logic [N_SRC-1:0][IDX_W-1:0] disp_src_reg_i;
  logic                        disp_dst_valid_i;
  logic [IDX_W-1:0]            disp_dst_reg_i;
  logic [TAG_W-1:0]            disp_dst_tag_i;
  logic                        cmpl_valid_i;
  logic [IDX_W-1:0]            cmpl_reg_i;
  logic [TAG_W-1:0]            cmpl_tag_i;
  logic                        ret_valid_i;
  logic [IDX_W-1:0]            ret_reg_i;
  logic [TAG_W-1:0]            ret_tag_i;
  logic [N_SRC-1:0][1:0]       src_kind_o;
  logic [N_SRC-1:0][TAG_W-1:0] src_tag_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .N_SRC(N_SRC)) i_rename_map_table (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .disp_valid_i(disp_valid_i), .disp_ready_o(disp_ready_o),
    .disp_src_valid_i(disp_src_valid_i), .disp_src_reg_i(disp_src_reg_i),
    .disp_dst_valid_i(disp_dst_valid_i), .disp_dst_reg_i(disp_dst_reg_i),
    .disp_dst_tag_i(disp_dst_tag_i),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_reg_i(cmpl_reg_i), .cmpl_tag_i(cmpl_tag_i),
    .ret_valid_i(ret_valid_i), .ret_reg_i(ret_reg_i), .ret_tag_i(ret_tag_i),
    .src_kind_o(src_kind_o), .src_tag_o(src_tag_o)
  );

  task automatic clear_inputs();
    flush_i = 0; disp_valid_i = 0; disp_src_valid_i = '0; disp_src_reg_i = '0;
    disp_dst_valid_i = 0; disp_dst_reg_i = '0; disp_dst_tag_i = '0;
    cmpl_valid_i = 0; cmpl_reg_i = '0; cmpl_tag_i = '0;
    ret_valid_i = 0; ret_reg_i = '0; ret_tag_i = '0;
  endtask

  task automatic check_src(string req, int s, logic [1:0] kexp, logic [TAG_W-1:0] texp);
    n_checks++;
    if (src_kind_o[s] !== kexp || src_tag_o[s] !== texp) begin
      n_fail++;
      $display("FAIL %s src%0d: kind=%0d tag=%0d expected kind=%0d tag=%0d",
               req, s, src_kind_o[s], src_tag_o[s], kexp, texp);
    end
  endtask

  // Look up one register with no other activity; called at a negedge.
  task automatic peek(string req, int r, logic [1:0] kexp, logic [TAG_W-1:0] texp);
    clear_inputs();
    disp_src_valid_i[0] = 1'b1;
    disp_src_reg_i[0]   = IDX_W'(r);
    #1 check_src(req, 0, kexp, texp);
    @(negedge clk);
  endtask

  task automatic dispatch(int r, int t);
    clear_inputs();
    disp_valid_i = 1; disp_dst_valid_i = 1;
    disp_dst_reg_i = IDX_W'(r); disp_dst_tag_i = TAG_W'(t);
    @(negedge clk);
  endtask

  task automatic complete(int r, int t);
    clear_inputs();
    cmpl_valid_i = 1; cmpl_reg_i = IDX_W'(r); cmpl_tag_i = TAG_W'(t);
    @(negedge clk);
  endtask

  task automatic retire(int r, int t);
    clear_inputs();
    ret_valid_i = 1; ret_reg_i = IDX_W'(r); ret_tag_i = TAG_W'(t);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    clear_inputs();
    disp_src_valid_i = '1;
    disp_src_reg_i[0] = IDX_W'(3); disp_src_reg_i[1] = IDX_W'(NUM_REGS-1);
    #1;
    check_src("R1", 0, K_RF, '0);
    check_src("R1", 1, K_RF, '0);
    @(negedge clk);
  endtask

  task automatic t_rename_complete_retire();
    dispatch(5, 3);
    peek("R2", 5, K_WAIT, 6'd3);
    complete(5, 3);
    peek("R3", 5, K_ROB, 6'd3);
    retire(5, 3);
    peek("R5", 5, K_RF, '0);
  endtask

  task automatic t_stale_events();
    dispatch(6, 4);
    dispatch(6, 7);
    complete(6, 4);
    peek("R4", 6, K_WAIT, 6'd7);
    complete(6, 7);
    retire(6, 4);
    peek("R6", 6, K_ROB, 6'd7);
    retire(6, 7);
    peek("R5", 6, K_RF, '0);
  endtask

  task automatic t_lookup_before_write();
    dispatch(1, 2);
    clear_inputs();
    disp_valid_i = 1; disp_dst_valid_i = 1;
    disp_dst_reg_i = IDX_W'(1); disp_dst_tag_i = TAG_W'(9);
    disp_src_valid_i = 2'b11;
    disp_src_reg_i[0] = IDX_W'(1); disp_src_reg_i[1] = IDX_W'(2);
    #1;
    check_src("R7", 0, K_WAIT, 6'd2);
    check_src("R12", 1, K_RF, '0);
    @(negedge clk);
    peek("R2", 1, K_WAIT, 6'd9);
  endtask

  task automatic t_bypass();
    clear_inputs();
    cmpl_valid_i = 1; cmpl_reg_i = IDX_W'(1); cmpl_tag_i = TAG_W'(9);
    disp_src_valid_i = 2'b11;
    disp_src_reg_i[0] = IDX_W'(1); disp_src_reg_i[1] = IDX_W'(1);
    #1;
    check_src("R8", 0, K_ROB, 6'd9);
    check_src("R8", 1, K_ROB, 6'd9);
    @(negedge clk);
    clear_inputs();
    ret_valid_i = 1; ret_reg_i = IDX_W'(1); ret_tag_i = TAG_W'(9);
    disp_src_valid_i = 2'b01; disp_src_reg_i[0] = IDX_W'(1);
    #1 check_src("R9", 0, K_RF, '0);
    @(negedge clk);
    peek("R5", 1, K_RF, '0);
  endtask

  task automatic t_collisions();
    dispatch(2, 5);
    clear_inputs();
    disp_valid_i = 1; disp_dst_valid_i = 1;
    disp_dst_reg_i = IDX_W'(2); disp_dst_tag_i = TAG_W'(6);
    cmpl_valid_i = 1; cmpl_reg_i = IDX_W'(2); cmpl_tag_i = TAG_W'(5);
    @(negedge clk);
    peek("R10", 2, K_WAIT, 6'd6);
    complete(2, 6);
    clear_inputs();
    disp_valid_i = 1; disp_dst_valid_i = 1;
    disp_dst_reg_i = IDX_W'(2); disp_dst_tag_i = TAG_W'(8);
    ret_valid_i = 1; ret_reg_i = IDX_W'(2); ret_tag_i = TAG_W'(6);
    @(negedge clk);
    peek("R10", 2, K_WAIT, 6'd8);
  endtask

  task automatic t_flush();
    dispatch(8, 10);
    clear_inputs();
    flush_i = 1; disp_valid_i = 1; disp_dst_valid_i = 1;
    disp_dst_reg_i = IDX_W'(9); disp_dst_tag_i = TAG_W'(11);
    #1;
    n_checks++;
    if (disp_ready_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 disp_ready_o=%0b expected 0", disp_ready_o);
    end
    @(negedge clk);
    peek("R1", 8, K_RF, '0);
    peek("R11", 9, K_RF, '0);
    peek("R1", 2, K_RF, '0);
    clear_inputs();
    #1;
    n_checks++;
    if (disp_ready_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 disp_ready_o=%0b expected 1", disp_ready_o);
    end
  endtask

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_rename_complete_retire();
    t_stale_events();
    t_lookup_before_write();
    t_bypass();
    t_collisions();
    t_flush();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule